// File: doc/BRIEF.md
# Dual-Wiper Serial Setting Register

This block is the digital control section of a two-channel digital potentiometer. A host drives three slow serial lines: a select line that frames a transfer, a serial clock and a data line. Every rising serial clock inside a frame pushes one data bit into a 17-bit register. That register holds a stack-select flag and two 8-bit wiper codes, and each code picks one of 256 tap positions. The bit that drops out of the far end of the register leaves on a cascade output. That output feeds the data line of the next device, so one bus can serve a chain of devices.

The serial lines are asynchronous to the block clock. They pass through synchronizer stages and are then edge-detected. When the select line rises, the register is loaded from the settings in force, so the host can read them back on the cascade line while it shifts new ones in. The wiper and stack-select outputs take the register contents only when the select line falls. A frame in progress therefore never moves a wiper.

Top module: `ser3w_wiper_port`

## Requirements
- R1: While rst_n is low, both wiper outputs, stack_sel and ser_cascade are 0, and they remain 0 after reset until a frame is committed.
- R2: While ser_sel is low, toggling ser_clk and ser_din changes no output.
- R3: A rising ser_sel loads the register from the active settings (bit 0 = stack_sel; bits 1..8 = wiper1 with its MSB in bit 1; bits 9..16 = wiper0 with its MSB in bit 9), so ser_cascade then shows wiper0 bit 0.
- R4: Each rising ser_clk while ser_sel is high moves every register bit one place toward bit 16 and puts ser_din into bit 0. ser_cascade always shows bit 16.
- R5: A falling ser_sel copies the register to the outputs with the field layout given in R3.
- R6: wiper0, wiper1 and stack_sel do not change while ser_sel is high.
- R7: A frame with fewer than 17 clocks commits the partly shifted register. A frame with no clocks leaves every setting unchanged.
- R8: In a chain of two devices, where the second device's ser_din is the first device's ser_cascade, a 34-clock frame sets the far device from the first 17 bits sent and the near device from the last 17 bits.
- R9: During a frame, the bits that ser_cascade presents before each clock are the previous settings, wiper0 LSB first, which allows readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | Frame select; high enables shifting, its fall commits |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_din | input | 1 | Serial data in |
| wiper0 | output | 8 | Active tap code of channel 0 |
| wiper1 | output | 8 | Active tap code of channel 1 |
| stack_sel | output | 1 | Active stack-select flag |
| ser_cascade | output | 1 | Register bit 16, to the next device's data input |

## Verification
Two devices are chained, and full 34-bit frames are sent with directed extreme codes (all ones, all zeros, alternating). These frames separate the field order and the bit order within each code, and they confirm the hand-over between the two devices. Readback frames compare the bits leaving the far device with its old settings. Empty and short frames show whether a commit without a full shift leaves the settings unchanged or mixes old and new bits. Clock and data activity with the select line low, and randomly sized frames of random data from 0 to 40 clocks, test the edge decoding, the chain overflow and the rule that the outputs stay fixed while a frame is open.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    localparam int DEF_WIPER_W   = 8;
    localparam int DEF_SYNC_DEPTH = 2;

    // serial event decoded from the synchronized lines, one per clk
    typedef enum logic [1:0] {
        EV_NONE,
        EV_LOAD,
        EV_SHIFT,
        EV_COMMIT
    } ser_ev_e;

    function automatic int frame_len(input int wiper_w);
        return 2 * wiper_w + 1;
    endfunction

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ser3w_core.sv
module ser3w_core
    import ser3w_pkg::*;
#(
    parameter int WIPER_W = DEF_WIPER_W,
    localparam int FL     = 2 * WIPER_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               sclk_i,
    input  logic               din_i,
    output logic [WIPER_W-1:0] wiper0_o,
    output logic [WIPER_W-1:0] wiper1_o,
    output logic               stack_o,
    output logic [FL-1:0]      frame_o
);

    typedef struct packed {
        logic [FL-1:0]      frame;
        logic [WIPER_W-1:0] w0;
        logic [WIPER_W-1:0] w1;
        logic               stk;
        logic               sel_prev;
        logic               sclk_prev;
    } state_t;

    state_t  st_d, st_q;
    ser_ev_e ev;

    always_comb begin
        ev = EV_NONE;
        if (sel_i && !st_q.sel_prev)
            ev = EV_LOAD;
        else if (!sel_i && st_q.sel_prev)
            ev = EV_COMMIT;
        else if (sel_i && sclk_i && !st_q.sclk_prev)
            ev = EV_SHIFT;

        st_d           = st_q;
        st_d.sel_prev  = sel_i;
        st_d.sclk_prev = sclk_i;

        case (ev)
            EV_LOAD: begin
                st_d.frame[0] = st_q.stk;
                for (int k = 0; k < WIPER_W; k++) begin
                    st_d.frame[1 + k]           = st_q.w1[WIPER_W - 1 - k];
                    st_d.frame[1 + WIPER_W + k] = st_q.w0[WIPER_W - 1 - k];
                end
            end
            EV_SHIFT: begin
                st_d.frame = {st_q.frame[FL-2:0], din_i};
            end
            EV_COMMIT: begin
                st_d.stk = st_q.frame[0];
                for (int k = 0; k < WIPER_W; k++) begin
                    st_d.w1[WIPER_W - 1 - k] = st_q.frame[1 + k];
                    st_d.w0[WIPER_W - 1 - k] = st_q.frame[1 + WIPER_W + k];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wiper0_o = st_q.w0;
    assign wiper1_o = st_q.w1;
    assign stack_o  = st_q.stk;
    assign frame_o  = st_q.frame;

endmodule

// File: rtl/ser3w_wiper_port.sv
module ser3w_wiper_port
    import ser3w_pkg::*;
#(
    parameter int WIPER_W     = DEF_WIPER_W,
    parameter int SYNC_STAGES = DEF_SYNC_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_sel,
    input  logic               ser_clk,
    input  logic               ser_din,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1,
    output logic               stack_sel,
    output logic               ser_cascade
);

    localparam int FL = 2 * WIPER_W + 1;

    logic [2:0]    pins_s;
    logic          sel_s;
    logic          sclk_s;
    logic          din_s;
    logic [FL-1:0] frame;

    ser3w_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_sel, ser_clk, ser_din}),
        .q_o   (pins_s)
    );

    assign sel_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign din_s  = pins_s[0];

    ser3w_core #(
        .WIPER_W (WIPER_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel_s),
        .sclk_i   (sclk_s),
        .din_i    (din_s),
        .wiper0_o (wiper0),
        .wiper1_o (wiper1),
        .stack_o  (stack_sel),
        .frame_o  (frame)
    );

    assign ser_cascade = frame[FL-1];

endmodule

// File: rtl/ser3w_wiper_chk.sv
module ser3w_wiper_chk #(
    parameter int WIPER_W = 8,
    localparam int FL     = 2 * WIPER_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sel_s,
    input logic               sclk_s,
    input logic               din_s,
    input logic [FL-1:0]      frame,
    input logic [WIPER_W-1:0] wiper0,
    input logic [WIPER_W-1:0] wiper1,
    input logic               stack_sel,
    input logic               ser_cascade
);

    logic sel_p, sclk_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_p  <= 1'b0;
            sclk_p <= 1'b0;
        end else begin
            sel_p  <= sel_s;
            sclk_p <= sclk_s;
        end
    end

    function automatic logic [WIPER_W-1:0] rev(input logic [WIPER_W-1:0] v);
        logic [WIPER_W-1:0] r;
        for (int i = 0; i < WIPER_W; i++) r[i] = v[WIPER_W - 1 - i];
        return r;
    endfunction

    // settings move only right after a select fall
    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(wiper0) && $stable(wiper1) && $stable(stack_sel))
            |-> $past(!sel_s && sel_p));

    // cascade never moves while the port is idle
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_cascade) |-> $past(sel_s));

    assert_load_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && !sel_p) |=> (ser_cascade == $past(wiper0[0]))
                              && (frame[0] == $past(stack_sel)));

    assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && sel_p && sclk_s && !sclk_p)
            |=> (ser_cascade == $past(frame[FL-2])) && (frame[0] == $past(din_s)));

    assert_commit_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && sel_p)
            |=> (stack_sel == $past(frame[0]))
                && (wiper1 == rev($past(frame[WIPER_W:1])))
                && (wiper0 == rev($past(frame[FL-1:WIPER_W+1]))));

endmodule

bind ser3w_wiper_port ser3w_wiper_chk #(.WIPER_W(WIPER_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (sel_s),
    .sclk_s      (sclk_s),
    .din_s       (din_s),
    .frame       (frame),
    .wiper0      (wiper0),
    .wiper1      (wiper1),
    .stack_sel   (stack_sel),
    .ser_cascade (ser_cascade)
);

// File: tb/tb_ser3w_wiper_port.sv
module tb_ser3w_wiper_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic [7:0] a_w0, a_w1, b_w0, b_w1;
    logic a_st, b_st, a_cas, b_cas;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    ser3w_wiper_port dut (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_din(ser_din), .wiper0(a_w0), .wiper1(a_w1), .stack_sel(a_st),
        .ser_cascade(a_cas)
    );

    ser3w_wiper_port dut_b (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_din(a_cas), .wiper0(b_w0), .wiper1(b_w1), .stack_sel(b_st),
        .ser_cascade(b_cas)
    );

    // reference model: register and active settings of both devices
    logic [16:0] ma_f = '0, mb_f = '0;
    logic [7:0]  ma_w0 = '0, ma_w1 = '0, mb_w0 = '0, mb_w1 = '0;
    logic        ma_st = 1'b0, mb_st = 1'b0;

    function automatic logic [16:0] pack(input logic [7:0] w0, input logic [7:0] w1,
                                         input logic st);
        logic [16:0] f;
        f[0] = st;
        for (int k = 0; k < 8; k++) begin
            f[1 + k] = w1[7 - k];
            f[9 + k] = w0[7 - k];
        end
        return f;
    endfunction

    function automatic logic [7:0] field(input logic [16:0] f, input int msb_pos);
        logic [7:0] w;
        for (int k = 0; k < 8; k++) w[7 - k] = f[msb_pos + k];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " near wiper0"}, 32'(a_w0), 32'(ma_w0));
        chk({tag, " near wiper1"}, 32'(a_w1), 32'(ma_w1));
        chk({tag, " near stack"},  32'(a_st), 32'(ma_st));
        chk({tag, " near cascade"}, 32'(a_cas), 32'(ma_f[16]));
        chk({tag, " far wiper0"},  32'(b_w0), 32'(mb_w0));
        chk({tag, " far wiper1"},  32'(b_w1), 32'(mb_w1));
        chk({tag, " far stack"},   32'(b_st), 32'(mb_st));
        chk({tag, " far cascade"}, 32'(b_cas), 32'(mb_f[16]));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_up();
        wait_clk(1);
        ser_sel = 1'b1;
        wait_clk(10);
        ma_f = pack(ma_w0, ma_w1, ma_st);
        mb_f = pack(mb_w0, mb_w1, mb_st);
        check_all("R3 load");
    endtask

    task automatic send_bit(input logic b);
        logic carry;
        wait_clk(1);
        ser_din = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(10);
        ser_clk = 1'b0;
        wait_clk(4);
        carry = ma_f[16];
        ma_f  = {ma_f[15:0], b};
        mb_f  = {mb_f[15:0], carry};
        check_all("R4/R6 shift");
    endtask

    task automatic sel_down(input string tag);
        wait_clk(1);
        ser_sel = 1'b0;
        wait_clk(10);
        ma_w0 = field(ma_f, 9); ma_w1 = field(ma_f, 1); ma_st = ma_f[0];
        mb_w0 = field(mb_f, 9); mb_w1 = field(mb_f, 1); mb_st = mb_f[0];
        check_all(tag);
    endtask

    task automatic idle_toggle(input int n);
        for (int i = 0; i < n; i++) begin
            wait_clk(1);
            ser_din = 1'($urandom);
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(8);
            ser_clk = 1'b0;
            wait_clk(4);
        end
        check_all("R2 idle");
    endtask

    task automatic write_chain(input logic [7:0] fw0, input logic [7:0] fw1, input logic fst,
                               input logic [7:0] nw0, input logic [7:0] nw1, input logic nst);
        logic [16:0] ff, nf;
        ff = pack(fw0, fw1, fst);
        nf = pack(nw0, nw1, nst);
        sel_up();
        for (int i = 16; i >= 0; i--) send_bit(ff[i]);
        for (int i = 16; i >= 0; i--) send_bit(nf[i]);
        sel_down("R5 commit");
        chk("R8 far wiper0", 32'(b_w0), 32'(fw0));
        chk("R8 far wiper1", 32'(b_w1), 32'(fw1));
        chk("R8 far stack",  32'(b_st), 32'(fst));
        chk("R8 near wiper0", 32'(a_w0), 32'(nw0));
        chk("R8 near wiper1", 32'(a_w1), 32'(nw1));
        chk("R8 near stack",  32'(a_st), 32'(nst));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [16:0] old_far;
        void'($urandom(32'h1d5eed));

        // R1: reset state
        wait_clk(5);
        check_all("R1 in reset");
        rst_n = 1'b1;
        wait_clk(5);
        check_all("R1 after reset");

        idle_toggle(4);

        // R5 / R8: directed extreme codes across the chain
        write_chain(8'hFF, 8'h00, 1'b1, 8'h00, 8'hFF, 1'b0);
        write_chain(8'hA5, 8'h3C, 1'b0, 8'h81, 8'h7E, 1'b1);
        write_chain(8'h01, 8'h80, 1'b1, 8'h55, 8'hAA, 1'b1);

        // R9: readback of far device while rewriting it unchanged
        old_far = pack(b_w0, b_w1, b_st);
        sel_up();
        for (int i = 16; i >= 0; i--) begin
            chk("R9 readback bit", 32'(b_cas), 32'(old_far[i]));
            send_bit(old_far[i]);
        end
        for (int i = 16; i >= 0; i--) send_bit(1'($urandom));
        sel_down("R9 rewrite");
        chk("R9 far kept", 32'(pack(b_w0, b_w1, b_st)), 32'(old_far));

        // R7: empty frame and a short frame
        sel_up();
        sel_down("R7 empty frame");
        sel_up();
        for (int i = 0; i < 5; i++) send_bit(1'(i & 1));
        sel_down("R7 short frame");

        idle_toggle(3);

        // random frames of 0..40 clocks
        for (int it = 0; it < 40; it++) begin
            int n;
            n = $urandom_range(0, 40);
            sel_up();
            for (int i = 0; i < n; i++) send_bit(1'($urandom));
            sel_down("R5/R7 random frame");
            if ($urandom_range(0, 3) == 0) idle_toggle(2);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule